// File: doc/BRIEF.md
# Write-Back Cache Maintenance Engine

This block holds the line storage of a two-way set-associative data cache and carries out maintenance commands on it. The cache is write-back and write-allocate, with 16-byte lines of four 32-bit words. Physical addresses are 36 bits wide and are split into a 24-bit tag in bits 35:12, a set index in bits 11:4 (256 sets) and a word select in bits 3:2. A command is accepted in any cycle in which the engine is idle. It carries a 3-bit operation code and an address. Depending on the code, the line is found either by tag lookup (hit commands) or by set index plus way bit (index commands).

The engine can write a dirty line back to memory, invalidate a line, move a line's tag, state and parity into a software-visible tag register, copy that register into a line, or create a dirty line without reading memory. Write-back and invalidate are separate actions, and neither implies the other. Ordinary CPU stores also pass through the engine. A store hit updates the word and marks the line dirty. A store miss evicts the victim way (writing it back first if it is dirty) and then fills the line with a four-beat burst from memory. Memory transfers use a single request/acknowledge port, one word per acknowledge.

Top module: `wb_cache_maint`

## Requirements
- R1: The hit commands (code 4 hit invalidate, 5 hit write-back-invalidate, 6 hit write-back) do nothing when the address tag matches no valid line in its set. There is no memory traffic, and both lines keep their tag and state.
- R2: The index commands (code 0 index write-back-invalidate, 1 index load tag, 2 index store tag) act on the line chosen by address bits 11:4 (set) and bit 12 (way), whatever that line contains. The other way of the set is not touched.
- R3: Hit write-back (code 6) on a dirty line writes its four words to memory and leaves the line valid and clean (state 01). On a clean line it makes no memory access.
- R4: Invalidation (code 4, or code 0/5 on a clean line) sets the line state to 00 without any write to memory, so the data of an invalidated dirty line is lost. Codes 0 and 5 on a dirty line first write it back and then invalidate it.
- R5: The tag register is 27 bits wide: tag in bits 26:3, state in bits 2:1 (00 invalid, 01 valid clean, 1x valid dirty) and parity in bit 0. Store tag (code 2) copies it unchanged into the line, parity included and unchecked. Load tag (code 1) copies the line's tag, state and parity back. A tag_wr input writes the register directly.
- R6: A CPU store that hits writes its word into the line and sets the state to 11 with no memory access.
- R7: A CPU store that misses first writes back the victim if it is dirty, then reads the four words of the line from memory. It merges the store word and installs the line with state 11 and parity equal to the XOR of the tag bits (even parity, so an all-zero register is correct).
- R8: Create dirty (code 3) never reads memory. On a hit it zeroes the line's data and sets state 11. On a miss it writes back a dirty victim and then installs the new tag with state 11, computed parity and zeroed data.
- R9: Each set has a replacement bit, cleared at reset, that picks the way a miss allocates. Each allocation points the bit at the other way. Store tag to way w points it at the way other than w.
- R10: A memory write burst runs over words 0 to 3 of the line in order. Each word's address and data are held until mem_ack. busy is high from the cycle after acceptance until the last acknowledge of the burst. Commands and stores presented while busy is high are ignored.
- R11: After reset all lines are invalid with zero tag and parity, the tag register is zero, busy is low and no memory request is active.
- R12: Operation code 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Maintenance command present |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | 36 | Command physical address |
| st_valid | input | 1 | CPU store present |
| st_addr | input | 36 | CPU store physical address |
| st_data | input | 32 | CPU store word |
| tag_wr | input | 1 | Direct write of the tag register |
| tag_wdata | input | 27 | Value for the tag register |
| tag_reg | output | 27 | Tag register {tag, state, parity} |
| busy | output | 1 | Engine is in a memory burst |
| mem_wr | output | 1 | Memory write request |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 36 | Word address of the current beat |
| mem_wdata | output | 32 | Write data of the current beat |
| mem_ack | input | 1 | Memory acknowledges the current beat |
| mem_rdata | input | 32 | Read data, valid with mem_ack on reads |

## Verification
A wrong state or dirty bit is not visible at once. It appears at the next write-back as a missing or extra four-beat burst, or at the next index load tag as a wrong state field, usually within a few commands. A wrong replacement bit shows only at the second miss in the same set, when the fill lands in the unexpected way and evicts a line that should have survived. Wrong word order or address bits in a burst show at the memory port in the burst itself, so the bench compares every beat's address and data against values built from the tag, the set and the words stored earlier.

// File: rtl/wb_cache_maint.sv
module wb_cache_maint (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [35:0] cmd_addr,
  input  logic        st_valid,
  input  logic [35:0] st_addr,
  input  logic [31:0] st_data,
  input  logic        tag_wr,
  input  logic [26:0] tag_wdata,
  output logic [26:0] tag_reg,
  output logic        busy,
  output logic        mem_wr,
  output logic        mem_rd,
  output logic [35:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int SETS  = 256;
  localparam int LINES = 2 * SETS;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL} fsm_t;
  typedef enum logic [1:0] {A_INV, A_CLEAN, A_ZERO, A_FILL} act_t;

  logic [LINES-1:0][23:0] tg;
  logic [LINES-1:0][1:0]  sf;
  logic [LINES-1:0]       pb;
  logic [SETS-1:0]        nxt;
  logic [31:0]            dw [LINES*4];

  fsm_t        fsm;
  act_t        act;
  logic [8:0]  ln, tl;
  logic [23:0] ntag;
  logic [1:0]  beat, sw;
  logic [31:0] sd;

  wire        idle     = (fsm == S_IDLE);
  wire        take_cmd = idle && cmd_valid;
  wire        take_st  = idle && !cmd_valid && st_valid;
  wire [35:0] la       = cmd_valid ? cmd_addr : st_addr;
  wire [7:0]  lset     = la[11:4];
  wire [23:0] ltag     = la[35:12];
  wire        h0       = (|sf[{lset, 1'b0}]) && (tg[{lset, 1'b0}] == ltag);
  wire        h1       = (|sf[{lset, 1'b1}]) && (tg[{lset, 1'b1}] == ltag);
  wire        hit      = h0 || h1;
  wire [8:0]  hln      = {lset, ~h0};
  wire [8:0]  vln      = {lset, nxt[lset]};
  wire        tvalid   = |sf[tl];
  wire        tdirty   = sf[tl][1];

  always_comb begin
    tl = hit ? hln : vln;
    if (cmd_valid && cmd_op <= 3'd2) tl = {lset, cmd_addr[12]};
  end

  assign busy      = !idle;
  assign mem_wr    = (fsm == S_WB);
  assign mem_rd    = (fsm == S_FILL);
  assign mem_addr  = {(fsm == S_WB) ? tg[ln] : ntag, ln[8:1], beat, 2'b00};
  assign mem_wdata = dw[{ln, beat}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tg <= '0; sf <= '0; pb <= '0; nxt <= '0;
      fsm <= S_IDLE; act <= A_INV; tag_reg <= '0;
      ln <= '0; ntag <= '0; beat <= '0; sw <= '0; sd <= '0;
    end else begin
      if (tag_wr && !(take_cmd && cmd_op == 3'd1)) tag_reg <= tag_wdata;
      case (fsm)
        S_IDLE: begin
          if (take_cmd) begin
            ln <= tl; ntag <= ltag; beat <= '0;
            case (cmd_op)
              3'd0: if (tvalid && tdirty) begin fsm <= S_WB; act <= A_INV; end
                    else sf[tl] <= 2'b00;
              3'd1: tag_reg <= {tg[tl], sf[tl], pb[tl]};
              3'd2: begin
                {tg[tl], sf[tl], pb[tl]} <= tag_reg;
                nxt[lset] <= ~cmd_addr[12];
              end
              3'd3: begin
                if (!hit && tvalid && tdirty) begin
                  fsm <= S_WB; act <= A_ZERO;
                end else begin
                  sf[tl] <= 2'b11;
                  for (int k = 0; k < 4; k++) dw[{tl, k[1:0]}] <= '0;
                  if (!hit) begin
                    tg[tl] <= ltag; pb[tl] <= ^ltag; nxt[lset] <= ~tl[0];
                  end
                end
              end
              3'd4: if (hit) sf[tl] <= 2'b00;
              3'd5: if (hit) begin
                if (tdirty) begin fsm <= S_WB; act <= A_INV; end
                else sf[tl] <= 2'b00;
              end
              3'd6: if (hit && tdirty) begin fsm <= S_WB; act <= A_CLEAN; end
              default: ;
            endcase
          end else if (take_st) begin
            ln <= tl; ntag <= ltag; beat <= '0; sw <= st_addr[3:2]; sd <= st_data;
            if (hit) begin
              dw[{tl, st_addr[3:2]}] <= st_data;
              sf[tl] <= 2'b11;
            end else if (tvalid && tdirty) begin
              fsm <= S_WB; act <= A_FILL;
            end else fsm <= S_FILL;
          end
        end
        S_WB: if (mem_ack) begin
          beat <= beat + 2'd1;
          if (beat == 2'd3) begin
            fsm <= S_IDLE;
            case (act)
              A_INV:   sf[ln] <= 2'b00;
              A_CLEAN: sf[ln] <= 2'b01;
              A_ZERO: begin
                tg[ln] <= ntag; sf[ln] <= 2'b11; pb[ln] <= ^ntag;
                nxt[ln[8:1]] <= ~ln[0];
                for (int k = 0; k < 4; k++) dw[{ln, k[1:0]}] <= '0;
              end
              default: fsm <= S_FILL;
            endcase
          end
        end
        S_FILL: if (mem_ack) begin
          dw[{ln, beat}] <= (beat == sw) ? sd : mem_rdata;
          beat <= beat + 2'd1;
          if (beat == 2'd3) begin
            tg[ln] <= ntag; sf[ln] <= 2'b11; pb[ln] <= ^ntag;
            nxt[ln[8:1]] <= ~ln[0];
            fsm <= S_IDLE;
          end
        end
        default: fsm <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wb_cache_maint_chk.sv
module wb_cache_maint_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [2:0]  cmd_op,
  input logic        tag_wr,
  input logic [26:0] tag_wdata,
  input logic [26:0] tag_reg,
  input logic        busy,
  input logic        mem_wr,
  input logic [35:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack
);
  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && !mem_ack |=> mem_wr && $stable(mem_addr) && $stable(mem_wdata));
  // R10
  beat_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && mem_ack && mem_addr[3:2] != 2'b11 |=>
      mem_wr && mem_addr[3:2] == $past(mem_addr[3:2]) + 2'd1);
  // R4
  hit_inv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd_op == 3'd4 |=> !busy);
  // R5
  tag_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_wr && !(cmd_valid && !busy && cmd_op == 3'd1) |=> tag_reg == $past(tag_wdata));
  // R2
  load_tag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd_op == 3'd1 |=> !busy);
  // R12
  nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd_op == 3'd7 |=> !busy && $stable(tag_reg));
endmodule

bind wb_cache_maint wb_cache_maint_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .tag_wr(tag_wr), .tag_wdata(tag_wdata), .tag_reg(tag_reg), .busy(busy),
  .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/wb_cache_maint_bench.sv
`timescale 1ns/1ps
module wb_cache_maint_bench;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, st_valid = 0, tag_wr = 0;
  logic [2:0] cmd_op = 0;
  logic [35:0] cmd_addr = 0, st_addr = 0;
  logic [31:0] st_data = 0;
  logic [26:0] tag_wdata = 0, tag_reg;
  logic busy, mem_wr, mem_rd, mem_ack = 0;
  logic [35:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = 0;
  int nchk = 0, nfail = 0, nw = 0, nr = 0;
  logic [35:0] wa [16];
  logic [31:0] wd [16];

  always #10 clk = ~clk;

  wb_cache_maint u_wb_cache_maint (.*);

  localparam logic [62:0] VEC [5] = '{
    {36'h0_0000_0100, 27'h1234567}, {36'h0_0000_1100, 27'h7654321},
    {36'h0_0000_0FF0, 27'h0000007}, {36'h0_0000_1000, 27'h5555552},
    {36'h0_0000_0010, 27'h2AAAAA8}};

  localparam logic [23:0] T1 = 24'hA10001, T2 = 24'hB20002, T3 = 24'hC30003,
    T4 = 24'hD40004, T5 = 24'hE50005, T6 = 24'hF60006, T7 = 24'h170007,
    T8 = 24'h280008, T9 = 24'h390009, TA = 24'h4A000A;

  function automatic logic [35:0] mk(logic [23:0] t, logic [7:0] s, logic [1:0] w);
    return {t, s, w, 2'b00};
  endfunction
  function automatic logic [35:0] idx(logic w, logic [7:0] s);
    return {23'd0, w, s, 4'd0};
  endfunction
  function automatic logic [31:0] fillv(logic [35:0] a);
    return a[31:0] ^ 32'h5A5A_0000;
  endfunction
  function automatic logic [26:0] dline(logic [23:0] t);
    return {t, 2'b11, ^t};
  endfunction

  initial forever begin
    @(negedge clk);
    mem_ack = mem_rd | mem_wr;
    mem_rdata = fillv(mem_addr);
    if (mem_wr && nw < 16) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; end
    if (mem_wr) nw++;
    if (mem_rd) nr++;
  end

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask
  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask
  task automatic do_cmd(input logic [2:0] op, input logic [35:0] a);
    cmd_valid = 1; cmd_op = op; cmd_addr = a;
    @(negedge clk); cmd_valid = 0;
    wait_idle();
  endtask
  task automatic do_st(input logic [35:0] a, input logic [31:0] d);
    st_valid = 1; st_addr = a; st_data = d;
    @(negedge clk); st_valid = 0;
    wait_idle();
  endtask
  task automatic set_tag(input logic [26:0] v);
    tag_wr = 1; tag_wdata = v;
    @(negedge clk); tag_wr = 0;
  endtask
  task automatic ld(input logic w, input logic [7:0] s);
    do_cmd(3'd1, idx(w, s));
  endtask
  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got hung expected idle");
    finish_run();
  end

  initial begin
    int bc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11
    chk("R11 busy", busy, 0);
    chk("R11 tag_reg", tag_reg, 0);
    chk("R11 mem req", {mem_wr, mem_rd}, 0);
    ld(1, 8'h05);
    chk("R11 line after reset", tag_reg, 0);

    // R5 R2 table walk
    for (int i = 0; i < 5; i++) begin
      set_tag(VEC[i][26:0]);
      do_cmd(3'd2, VEC[i][62:27]);
      set_tag(27'd0);
      do_cmd(3'd1, VEC[i][62:27]);
      chk("R5 store/load tag", tag_reg, VEC[i][26:0]);
    end
    do_cmd(3'd1, VEC[0][62:27]);
    chk("R2 other way untouched", tag_reg, VEC[0][26:0]);

    // R7 store miss fill, R6 store hit
    nw = 0; nr = 0;
    do_st(mk(T1, 8'h20, 2), 32'h1111_2222);
    chk("R7 fill reads", nr, 4);
    chk("R7 no victim write", nw, 0);
    ld(0, 8'h20);
    chk("R7 installed dirty", tag_reg, dline(T1));
    do_st(mk(T1, 8'h20, 0), 32'h3333_4444);
    chk("R6 hit no memory", {nr[7:0], nw[7:0]}, {8'd4, 8'd0});

    // R3 write-back dirty then clean
    do_cmd(3'd6, mk(T1, 8'h20, 0));
    chk("R3 wb beats", nw, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R10 wb addr", wa[k], mk(T1, 8'h20, k[1:0]));
    end
    chk("R6 word0", wd[0], 32'h3333_4444);
    chk("R7 word1 filled", wd[1], fillv(mk(T1, 8'h20, 1)));
    chk("R7 word2 merged", wd[2], 32'h1111_2222);
    chk("R7 word3 filled", wd[3], fillv(mk(T1, 8'h20, 3)));
    ld(0, 8'h20);
    chk("R3 clean after wb", tag_reg, {T1, 2'b01, ^T1});
    do_cmd(3'd6, mk(T1, 8'h20, 0));
    chk("R3 clean no-op", nw, 4);

    // R9 replacement order
    nr = 0;
    do_st(mk(T2, 8'h20, 1), 32'h5555_6666);
    ld(1, 8'h20);
    chk("R9 second miss way1", tag_reg, dline(T2));
    do_st(mk(T3, 8'h20, 0), 32'h7777_8888);
    ld(0, 8'h20);
    chk("R9 third miss way0", tag_reg, dline(T3));
    chk("R9 clean victim no wb", nw, 4);

    // R4 hit invalidate dirty loses data; R1 miss no effect
    nw = 0;
    do_cmd(3'd4, mk(T2, 8'h20, 0));
    ld(1, 8'h20);
    chk("R4 invalidated", tag_reg[2:1], 2'b00);
    do_cmd(3'd6, mk(T2, 8'h20, 0));
    chk("R4 no wb after inv", nw, 0);
    do_cmd(3'd5, mk(T9, 8'h20, 0));
    chk("R1 miss no traffic", nw, 0);
    ld(0, 8'h20);
    chk("R1 line kept", tag_reg, dline(T3));
    do_cmd(3'd7, mk(T3, 8'h20, 0));
    ld(0, 8'h20);
    chk("R12 nop", {nw[7:0], tag_reg}, {8'd0, dline(T3)});

    // R2 R4 index write-back-invalidate
    do_cmd(3'd0, idx(0, 8'h20));
    chk("R4 index wb beats", nw, 4);
    chk("R4 index wb addr", wa[0], mk(T3, 8'h20, 0));
    chk("R4 index wb data", wd[0], 32'h7777_8888);
    ld(0, 8'h20);
    chk("R4 index inv state", tag_reg[2:1], 2'b00);

    // R8 create dirty
    nw = 0; nr = 0;
    do_cmd(3'd3, mk(T4, 8'h30, 0));
    chk("R8 no fetch", nr, 0);
    ld(0, 8'h30);
    chk("R8 line dirty", tag_reg, dline(T4));
    do_cmd(3'd6, mk(T4, 8'h30, 0));
    chk("R8 wb addr", wa[0], mk(T4, 8'h30, 0));
    chk("R8 zero data", {wd[0], wd[3]}, 64'd0);

    // R9 store tag moves replacement bit
    set_tag({T5, 2'b01, ^T5});
    do_cmd(3'd2, idx(0, 8'h40));
    do_st(mk(T6, 8'h40, 0), 32'h9999_AAAA);
    ld(1, 8'h40);
    chk("R9 after store tag way1", tag_reg, dline(T6));
    ld(0, 8'h40);
    chk("R9 way0 kept", tag_reg, {T5, 2'b01, ^T5});

    // R10 busy window and ignored command
    do_cmd(3'd3, mk(T7, 8'h50, 0));
    do_cmd(3'd3, mk(T8, 8'h50, 0));
    nw = 0; nr = 0; bc = 0;
    st_valid = 1; st_addr = mk(TA, 8'h50, 3); st_data = 32'hBEEF_0001;
    @(negedge clk); st_valid = 0;
    chk("R10 busy after accept", busy, 1);
    cmd_valid = 1; cmd_op = 3'd4; cmd_addr = mk(T8, 8'h50, 0);
    @(negedge clk); cmd_valid = 0;
    bc = 2;
    while (busy) begin @(negedge clk); bc++; end
    chk("R10 busy cycles", bc, 9);
    chk("R7 victim wb", {nw[7:0], nr[7:0]}, {8'd4, 8'd4});
    chk("R7 victim addr", wa[0], mk(T7, 8'h50, 0));
    ld(1, 8'h50);
    chk("R10 ignored while busy", tag_reg, dline(T8));
    ld(0, 8'h50);
    chk("R7 new line", tag_reg, dline(TA));

    finish_run();
  end
endmodule